// File: doc/BRIEF.md
# Transmit Driver Tristate Controller

This block decides, for each of eight transmit channels, whether the line driver is allowed to drive the line or must be held in high impedance. Several independent causes can tristate the drivers at the same time. A chip-wide pin and the reset bit act on every channel. Each channel also has its own tristate bit and its own power-down bit. Clock loss is the last cause. A lost master clock silences every channel. A lost transmit clock silences only its own channel.

A lost transmit clock is not a cause when that channel is looping received data back to the line, or when it is sending an internal pattern timed by the master clock. In both of those cases the transmit clock is not used. Clock presence is judged by watchdog counters that run on a free-running reference clock. The enables are registered, so the driver control never glitches.

Top module: `tx_hz_ctrl`

## Requirements
- R1: While `hz_pin` is 1, every bit of `oe` is 0 in the following reference cycle.
- R2: A 1 in bit i of `ch_hz` clears `oe[i]` in the following cycle and leaves the other channels unaffected.
- R3: A 1 in bit i of `pdn` (transmit path powered down) clears `oe[i]` in the following cycle.
- R4: `oe` is all zero while `rst_n` is low and while `sw_reset` is 1. After reset it stays zero until the master clock has been found present.
- R5: While the master clock is judged lost, every bit of `oe` is 0.
- R6: While the transmit clock of channel i is judged lost, `oe[i]` is 0, unless R7 applies.
- R7: A lost transmit clock is ignored for channel i when `rlb[i]` (remote loopback) or `pat_mclk[i]` (internal pattern on master clock) is 1.
- R8: Each monitored clock passes through a two-flop synchronizer and a rising-edge detector. The clock is judged lost once 64 reference cycles pass with no detected edge, and every monitor starts out lost after reset. A 62-cycle clock period stays present, and a 66-cycle period is lost.
- R9: A lost clock is judged present again after 4 detected edges in a row, each arriving within 64 cycles of the one before. A longer gap restarts the count.
- R10: The clock monitors keep running while a channel is tristated by the pin or by its bit. A loss or recovery that happens meanwhile is already reflected when the tristate is released.
- R11: `oe[i]` is a registered NOR of all causes that apply to channel i. It changes one reference cycle after the causes are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous pin/power-on reset, active low |
| sw_reset | input | 1 | Software reset bit, holds all outputs in high impedance |
| hz_pin | input | 1 | Global tristate pin |
| ch_hz | input | 8 | Per-channel tristate bits |
| pdn | input | 8 | Per-channel transmit power-down bits |
| rlb | input | 8 | Per-channel remote loopback mode |
| pat_mclk | input | 8 | Per-channel internal pattern timed by master clock |
| mclk | input | 1 | Master clock being monitored |
| tclk | input | 8 | Per-channel transmit clocks being monitored |
| oe | output | 8 | Per-channel driver output enable, 1 = driving |

## Verification
The case of most interest is a clock-loss decision that falls on the same cycle as a change of the pin or a register bit. Examples are a transmit clock that times out while `hz_pin` is high, and a loopback bit set on the cycle a channel is declared lost. The bench runs monitored clocks with programmable half periods, stops and restarts them across these register changes, and uses periods on both sides of the 64-cycle window. A behavioural model tracks each clock's edge history and gap count. Every cycle, `oe` is compared with the model, and the result is also checked at chosen settle points.

// File: rtl/tx_hz_ctrl.sv
module tx_hz_ctrl #(
  parameter int NCH           = 8,
  parameter int LOSS_WIN      = 64,
  parameter int RECOVER_EDGES = 4
) (
  input  logic           ref_clk,
  input  logic           rst_n,
  input  logic           sw_reset,
  input  logic           hz_pin,
  input  logic [NCH-1:0] ch_hz,
  input  logic [NCH-1:0] pdn,
  input  logic [NCH-1:0] rlb,
  input  logic [NCH-1:0] pat_mclk,
  input  logic           mclk,
  input  logic [NCH-1:0] tclk,
  output logic [NCH-1:0] oe
);
  localparam int NMON = NCH + 1;
  localparam int CW   = $clog2(LOSS_WIN);
  localparam int GW   = $clog2(RECOVER_EDGES) + 1;

  logic [NMON-1:0] clk_in;
  logic [NMON-1:0] lost;
  logic [NCH-1:0]  cause;

  assign clk_in = {tclk, mclk};

  for (genvar g = 0; g < NMON; g++) begin : g_mon
    logic [2:0]    sy;
    logic [CW-1:0] gap;
    logic [GW-1:0] good;
    logic          lost_r;
    logic          rise;

    assign rise    = sy[1] & ~sy[2];
    assign lost[g] = lost_r;

    always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
        sy     <= '0;
        gap    <= '0;
        good   <= '0;
        lost_r <= 1'b1;
      end else begin
        sy <= {sy[1:0], clk_in[g]};
        if (rise) begin
          gap <= '0;
          if (lost_r) begin
            if (good == GW'(RECOVER_EDGES - 1)) begin
              lost_r <= 1'b0;
              good   <= '0;
            end else begin
              good <= good + 1'b1;
            end
          end
        end else if (gap == CW'(LOSS_WIN - 1)) begin
          lost_r <= 1'b1;
          good   <= '0;
        end else begin
          gap <= gap + 1'b1;
        end
      end
    end
  end

  assign cause = {NCH{sw_reset | hz_pin | lost[0]}} | ch_hz | pdn
               | (lost[NMON-1:1] & ~(rlb | pat_mclk));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) oe <= '0;
    else        oe <= ~cause;
  end
endmodule

module tx_hz_ctrl_chk #(
  parameter int NCH = 8
) (
  input logic           ref_clk,
  input logic           rst_n,
  input logic           sw_reset,
  input logic           hz_pin,
  input logic [NCH-1:0] ch_hz,
  input logic [NCH-1:0] pdn,
  input logic [NCH-1:0] rlb,
  input logic [NCH-1:0] pat_mclk,
  input logic [NCH:0]   lost,
  input logic [NCH-1:0] oe
);
  assert_pin_rst_R4: assert property (@(posedge ref_clk) !rst_n |-> oe == '0);

  assert_sw_rst_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sw_reset |=> oe == '0);

  assert_global_hz_R1: assert property (@(posedge ref_clk) disable iff (!rst_n)
    hz_pin |=> oe == '0);

  assert_chan_hz_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (|ch_hz) |=> (oe & $past(ch_hz)) == '0);

  assert_pdn_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (|pdn) |=> (oe & $past(pdn)) == '0);

  assert_mclk_lost_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    lost[0] |=> oe == '0);

  assert_tclk_lost_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (|(lost[NCH:1] & ~(rlb | pat_mclk))) |=> (oe & $past(lost[NCH:1] & ~(rlb | pat_mclk))) == '0);

  assert_loop_bypass_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!sw_reset && !hz_pin && !lost[0] && lost[1] && (rlb[0] || pat_mclk[0]) && !ch_hz[0] && !pdn[0])
    |=> oe[0]);
endmodule

bind tx_hz_ctrl tx_hz_ctrl_chk #(.NCH(NCH)) u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .sw_reset(sw_reset), .hz_pin(hz_pin),
  .ch_hz(ch_hz), .pdn(pdn), .rlb(rlb), .pat_mclk(pat_mclk),
  .lost(lost), .oe(oe)
);

// File: tb/tx_hz_ctrl_tb.sv
module tx_hz_ctrl_tb;
  localparam int NCH = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n = 1'b0, sw_reset = 1'b1, hz_pin = 1'b0, mclk = 1'b0;
  logic [NCH-1:0] ch_hz = '0, pdn = '0, rlb = '0, pat_mclk = '0, tclk = '0;
  logic [NCH-1:0] oe;

  tx_hz_ctrl u_dut (
    .ref_clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .hz_pin(hz_pin),
    .ch_hz(ch_hz), .pdn(pdn), .rlb(rlb), .pat_mclk(pat_mclk),
    .mclk(mclk), .tclk(tclk), .oe(oe)
  );

  int tests = 0, fails = 0;
  string ph = "R4";

  // clock sources: half period in reference cycles, 0 = stopped
  int mper = 3, mcnt = 0;
  int tper[NCH], tcnt[NCH];
  initial for (int i = 0; i < NCH; i++) begin tper[i] = 3; tcnt[i] = 0; end

  // behavioural reference model
  logic [2:0]     hist[NCH+1];
  int             gapc[NCH+1], goodc[NCH+1];
  bit             lst[NCH+1];
  logic [NCH-1:0] moe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      moe = '0;
      for (int m = 0; m <= NCH; m++) begin
        hist[m] = '0; gapc[m] = 0; goodc[m] = 0; lst[m] = 1'b1;
      end
    end else begin
      logic [NCH-1:0] nx;
      for (int i = 0; i < NCH; i++) begin
        bit tlost_eff;
        tlost_eff = lst[i+1] && !(rlb[i] || pat_mclk[i]);
        nx[i] = !(sw_reset || hz_pin || lst[0] || ch_hz[i] || pdn[i] || tlost_eff);
      end
      for (int m = 0; m <= NCH; m++) begin
        bit smp, seen;
        smp  = (m == 0) ? mclk : tclk[m-1];
        seen = hist[m][1] && !hist[m][2];
        hist[m] = {hist[m][1:0], smp};
        if (seen) begin
          gapc[m] = 0;
          if (lst[m]) begin
            goodc[m]++;
            if (goodc[m] == 4) begin lst[m] = 1'b0; goodc[m] = 0; end
          end
        end else if (gapc[m] == 63) begin
          lst[m] = 1'b1; goodc[m] = 0;
        end else gapc[m]++;
      end
      moe = nx;
    end
  end

  // per-cycle comparison and clock generation
  always @(negedge clk) begin
    tests++;
    if (oe !== moe) begin
      fails++;
      $display("FAIL %s cycle compare: oe=%h expected=%h", ph, oe, moe);
    end
    if (mper != 0) begin
      mcnt++;
      if (mcnt >= mper) begin mclk <= ~mclk; mcnt = 0; end
    end
    for (int i = 0; i < NCH; i++)
      if (tper[i] != 0) begin
        tcnt[i]++;
        if (tcnt[i] >= tper[i]) begin tclk[i] <= ~tclk[i]; tcnt[i] = 0; end
      end
  end

  task automatic chk(input string r, input logic [NCH-1:0] exp);
    tests++;
    if (oe !== exp) begin
      fails++;
      $display("FAIL %s settle check: oe=%h expected=%h", r, oe, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(4); chk("R4", '0);
    rst_n = 1'b1; step(60); chk("R4", '0);          // sw_reset held
    sw_reset = 1'b0; step(3); chk("R4", 8'hff);

    ph = "R1"; hz_pin = 1'b1; step(2); chk("R1", '0);
    hz_pin = 1'b0; step(2); chk("R1", 8'hff);

    ph = "R2"; ch_hz = 8'h05; step(2); chk("R2", 8'hfa);
    ch_hz = 8'h80; step(2); chk("R2", 8'h7f);
    ch_hz = '0;
    ph = "R3"; pdn = 8'h30; step(2); chk("R3", 8'hcf);
    pdn = '0; step(2); chk("R3", 8'hff);

    ph = "R6"; tper[2] = 0; step(100); chk("R6", 8'hfb);
    ph = "R7"; rlb[2] = 1'b1; step(2); chk("R7", 8'hff);
    rlb[2] = 1'b0; pat_mclk[2] = 1'b1; step(2); chk("R7", 8'hff);
    pat_mclk[2] = 1'b0; step(2); chk("R6", 8'hfb);
    ph = "R9"; tper[2] = 3; step(60); chk("R9", 8'hff);

    ph = "R5"; rlb[5] = 1'b1; mper = 0; step(100); chk("R5", '0);
    mper = 3; step(60); chk("R5", 8'hff); rlb[5] = 1'b0;

    ph = "R9"; tper[1] = 0; step(100); chk("R9", 8'hfd);
    tper[1] = 40; step(400); chk("R9", 8'hfd);     // gaps of 80 never recover
    tper[1] = 3; step(60); chk("R9", 8'hff);

    ph = "R8"; tper[3] = 31; step(400); chk("R8", 8'hff);
    tper[3] = 33; step(400); chk("R8", 8'hf7);
    tper[3] = 3; step(60); chk("R8", 8'hff);

    ph = "R10"; hz_pin = 1'b1; tper[6] = 0; step(100); chk("R10", '0);
    hz_pin = 1'b0; step(2); chk("R10", 8'hbf);
    hz_pin = 1'b1; tper[6] = 3; step(60);
    hz_pin = 1'b0; step(2); chk("R10", 8'hff);
    ch_hz[4] = 1'b1; tper[4] = 0; step(100);
    ch_hz[4] = 1'b0; step(2); chk("R10", 8'hef);
    tper[4] = 3; step(60); chk("R10", 8'hff);

    ph = "R11"; pdn[0] = 1'b1; @(posedge clk); #1 chk("R11", 8'hfe);
    pdn[0] = 1'b0; step(1); @(posedge clk); #1 chk("R11", 8'hff);

    ph = "R4"; step(2); sw_reset = 1'b1; step(2); chk("R4", '0);
    sw_reset = 1'b0; rst_n = 1'b0; step(2); chk("R4", '0);
    rst_n = 1'b1; step(5); chk("R4", '0); step(60); chk("R4", 8'hff);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule